// File: doc/BRIEF.md
# Paired-Channel PWM Generator

This block drives two pulse-width-modulated outputs from one set of control registers. Both channels take their time base from a single shared 8-bit prescaler. Each channel then has its own 3-bit divider. Each channel has its own 16-bit period and compare values and its own counting style:

- **Edge style:** a down-counter that reloads at the end of each period.
- **Centre style:** an up/down counter that gives a waveform symmetric about the turnaround point.

New period and compare values are held in shadow registers. They reach the counter only when the running period ends, so the output never shows a partly updated cycle.

Each channel keeps two sticky event flags, which are cleared by writing ones:

- a period event, which fires either at the bottom or at the top of the count;
- a duty event, which fires on a compare match in a chosen counting direction.

Each channel also emits a one-cycle converter-trigger pulse. The pulse is built from four conditions, each with its own enable:

- output rising edge;
- output falling edge;
- counter at the top value;
- counter reaching zero.

A plain write port (enable, address, data) loads all settings. Each channel has a run enable and an output polarity inverter.

Top module: `pwm_pair_gen`

## Requirements

All register and bit positions referred to here are listed in R12.

- R1: After reset, every output is 0: `pwm_out`, `period_flag`, `duty_flag` and `adc_trig`.
- R2: One prescaler value P serves both channels. The time base advances once every P+1 clock cycles. When P is 0, both channels stall and their outputs hold.
- R3: The 3-bit divider code sets how many time-base steps make one counter tick. Codes 4→1, 0→2, 1→4, 2→8, 3→16. Codes 5 to 7 act as 1.
- R4: Edge style with period N > 0:
  - the counter runs N, N-1, …, 0 and then reloads, so one period lasts N+1 ticks;
  - the output is high while the counter is below the compare value C, which gives C high ticks when C ≤ N+1.
- R5: Centre style with period N > 0:
  - the counter runs 0, 1, …, N and back down to 1, so one period lasts 2N ticks;
  - the output is high while the counter is below C, which gives 2C-1 high ticks when 1 ≤ C ≤ N.
- R6: A period or compare value written while the channel runs takes effect only when the counter next leaves 0. A period boundary is the tick at which the counter is 0.
- R7: A period of 0 stops the counter at 0. The output then holds its level, and no period event fires.
- R8: The inverter bit flips the polarity of the final output.
- R9: While its enable bit is 0, a channel holds its counter at 0 and its output at the idle level, which is low before inversion. It raises no events.
- R10: Period and duty events:
  - The period event fires at counter 0 when the top-select bit is 0, and at counter = period when it is 1.
  - The duty event fires on counter = compare, but only while counting up when the up-select bit is 1, and only otherwise when it is 0. Edge style never counts up.
  - Both flags stay set until a one is written to their clear bit.
- R11: `adc_trig[i]` pulses for one cycle on each enabled condition:
  - enable bit 0: output rise, and the pulse falls in the same cycle as the rise;
  - enable bit 1: output fall, and the pulse falls in the same cycle as the fall;
  - enable bit 2: counter at the period value;
  - enable bit 3: counter reaching 0.
- R12: Register map, by write address:

  | Address | Contents |
  |---|---|
  | 0 | prescaler |
  | 1 | control word. For channel i: bit i enable, bit 2+i centre style, bit 4+i invert, bit 6+i period-at-top, bit 8+i duty-on-up |
  | 2 | divider codes: channel i at bits 4i+2..4i |
  | 3 | trigger enables: channel i at bits 4i+3..4i |
  | 4 | write-one clear: bit 2i clears period flag i, bit 2i+1 clears duty flag i |
  | 5+2i | period of channel i |
  | 6+2i | compare of channel i |

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 2 | PWM outputs, one bit per channel |
| period_flag | output | 2 | Sticky period-event flags |
| duty_flag | output | 2 | Sticky duty-event flags |
| adc_trig | output | 2 | Single-cycle converter-trigger pulses |

## Verification

The bench measures high time and period in clock cycles for each of the following:

- every divider code it uses;
- both counting styles;
- an inverted output;
- the pair under a shared prescaler change.

A wrong divider decode, an off-by-one at the reload, or a centre count that visits the top twice would each show up as a wrong length.

Other faults are targeted directly:

- **Shadowing:** a compare write lands in the low phase of a period. If the value were applied at once, the low phase would be cut short.
- **Zero period and zero prescaler:** the bench requires a frozen output. A design that wraps the counter would keep toggling.
- **Duty direction:** the bench requires that the up-count duty event never fires in edge style.
- **Triggers:** each trigger source is counted alone, and the edge triggers must coincide with the output edges. A trigger tied to the wrong condition, or one lasting two cycles, would give the wrong count.

// File: rtl/pwmpair_pkg.sv
package pwmpair_pkg;

  // One shared prescaler feeds exactly one channel pair.
  localparam int PAIR = 2;

  // Write addresses.
  localparam int A_PSC  = 0;
  localparam int A_CTRL = 1;
  localparam int A_DIV  = 2;
  localparam int A_TRIG = 3;
  localparam int A_CLR  = 4;
  localparam int A_PER0 = 5;  // period of channel i at A_PER0 + 2*i, compare one above

  typedef struct packed {
    logic       en;
    logic       center;
    logic       inv;
    logic       per_at_top;
    logic       duty_on_up;
    logic [2:0] div;
    logic [3:0] trig_en;      // {bottom, top, fall, rise}
  } chan_cfg_t;

  // Low-bit mask of the divider counter that must be all ones for a tick.
  function automatic logic [3:0] div_mask(input logic [2:0] code);
    case (code)
      3'd0:    div_mask = 4'h1;
      3'd1:    div_mask = 4'h3;
      3'd2:    div_mask = 4'h7;
      3'd3:    div_mask = 4'hF;
      default: div_mask = 4'h0;
    endcase
  endfunction

endpackage

// File: rtl/pwmpair_regs.sv
module pwmpair_regs
  import pwmpair_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 8,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  output logic [PSC_W-1:0]            psc_o,
  output chan_cfg_t [PAIR-1:0]        cfg_o,
  output logic [PAIR-1:0][CNT_W-1:0]  per_o,
  output logic [PAIR-1:0][CNT_W-1:0]  cmp_o,
  output logic [PAIR-1:0]             clr_per_o,
  output logic [PAIR-1:0]             clr_duty_o
);

  localparam int CTRL_W = 5 * PAIR;
  localparam int DIV_W  = 4 * PAIR;

  logic [PSC_W-1:0]            psc_q,  psc_n;
  logic [CTRL_W-1:0]           ctrl_q, ctrl_n;
  logic [DIV_W-1:0]            div_q,  div_n;
  logic [DIV_W-1:0]            trg_q,  trg_n;
  logic [PAIR-1:0][CNT_W-1:0]  per_q,  per_n;
  logic [PAIR-1:0][CNT_W-1:0]  cmp_q,  cmp_n;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int target);
    hit = (a == ADDR_W'(target));
  endfunction

  always_comb begin
    psc_n  = psc_q;
    ctrl_n = ctrl_q;
    div_n  = div_q;
    trg_n  = trg_q;
    per_n  = per_q;
    cmp_n  = cmp_q;
    if (wr_en) begin
      if (hit(wr_addr, A_PSC))  psc_n  = wr_data[PSC_W-1:0];
      if (hit(wr_addr, A_CTRL)) ctrl_n = wr_data[CTRL_W-1:0];
      if (hit(wr_addr, A_DIV))  div_n  = wr_data[DIV_W-1:0];
      if (hit(wr_addr, A_TRIG)) trg_n  = wr_data[DIV_W-1:0];
      for (int i = 0; i < PAIR; i++) begin
        if (hit(wr_addr, A_PER0 + 2*i))     per_n[i] = wr_data[CNT_W-1:0];
        if (hit(wr_addr, A_PER0 + 2*i + 1)) cmp_n[i] = wr_data[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q  <= '0;
      ctrl_q <= '0;
      div_q  <= '0;
      trg_q  <= '0;
      per_q  <= '0;
      cmp_q  <= '0;
    end else begin
      psc_q  <= psc_n;
      ctrl_q <= ctrl_n;
      div_q  <= div_n;
      trg_q  <= trg_n;
      per_q  <= per_n;
      cmp_q  <= cmp_n;
    end
  end

  assign psc_o = psc_q;
  assign per_o = per_q;
  assign cmp_o = cmp_q;

  for (genvar i = 0; i < PAIR; i++) begin : g_dec
    assign cfg_o[i].en         = ctrl_q[i];
    assign cfg_o[i].center     = ctrl_q[PAIR + i];
    assign cfg_o[i].inv        = ctrl_q[2*PAIR + i];
    assign cfg_o[i].per_at_top = ctrl_q[3*PAIR + i];
    assign cfg_o[i].duty_on_up = ctrl_q[4*PAIR + i];
    assign cfg_o[i].div        = div_q[4*i +: 3];
    assign cfg_o[i].trig_en    = trg_q[4*i +: 4];
    assign clr_per_o[i]  = wr_en && hit(wr_addr, A_CLR) && wr_data[2*i];
    assign clr_duty_o[i] = wr_en && hit(wr_addr, A_CLR) && wr_data[2*i+1];
  end

endmodule

// File: rtl/pwmpair_psc.sv
module pwmpair_psc #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] psc,
  output logic             tick_o
);

  logic [PSC_W-1:0] cnt_q, cnt_n;
  logic             tick;

  always_comb begin
    tick  = (psc != '0) && (cnt_q >= psc);
    cnt_n = (tick || psc == '0) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign tick_o = tick;

  // R2: the shared time base never advances on two cycles in a row
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/pwmpair_chan.sv
module pwmpair_chan
  import pwmpair_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psc_tick,
  input  chan_cfg_t        cfg,
  input  logic [CNT_W-1:0] shd_per,
  input  logic [CNT_W-1:0] shd_cmp,
  input  logic             clr_per,
  input  logic             clr_duty,
  output logic             pwm_o,
  output logic             per_flag_o,
  output logic             duty_flag_o,
  output logic             trig_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_n, act_per_q, act_per_n, act_cmp_q, act_cmp_n;
  logic [3:0]       div_q, div_n, mask;
  logic             up_q, up_n, pwm_q, pwm_d;
  logic             per_f_q, per_f_n, duty_f_q, duty_f_n, trig_q, trig_n;
  logic             tick, live, at_top, at_bot, going_up, duty_hit, per_hit;
  logic             rise, fall;

  // Event decode
  always_comb begin
    mask     = div_mask(cfg.div);
    tick     = cfg.en && psc_tick && ((div_q & mask) == mask);
    live     = tick && (act_per_q != '0);
    at_top   = live && (cnt_q == act_per_q);
    at_bot   = live && (cnt_q == '0);
    going_up = cfg.center && up_q;
    duty_hit = live && (cnt_q == act_cmp_q) && (cfg.duty_on_up == going_up);
    per_hit  = cfg.per_at_top ? at_top : at_bot;
    pwm_d    = cfg.en && (cnt_q < act_cmp_q);
    rise     = pwm_d && !pwm_q;
    fall     = !pwm_d && pwm_q;
  end

  // Counter, shadow transfer and flag next state
  always_comb begin
    div_n     = cfg.en ? (psc_tick ? div_q + 4'd1 : div_q) : 4'd0;
    cnt_n     = cnt_q;
    up_n      = up_q;
    act_per_n = act_per_q;
    act_cmp_n = act_cmp_q;
    if (!cfg.en) begin
      cnt_n     = '0;
      up_n      = 1'b1;
      act_per_n = shd_per;
      act_cmp_n = shd_cmp;
    end else if (tick) begin
      if (cnt_q == '0) begin
        act_per_n = shd_per;
        act_cmp_n = shd_cmp;
        up_n      = 1'b1;
        if (cfg.center) cnt_n = (shd_per != '0) ? ONE : '0;
        else            cnt_n = shd_per;
      end else if (going_up && cnt_q < act_per_q) begin
        cnt_n = cnt_q + 1'b1;
      end else begin
        cnt_n = cnt_q - 1'b1;
        up_n  = 1'b0;
      end
    end
    per_f_n  = per_hit  || (per_f_q  && !clr_per);
    duty_f_n = duty_hit || (duty_f_q && !clr_duty);
    trig_n   = |(cfg.trig_en & {at_bot, at_top, fall, rise});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      up_q      <= 1'b1;
      act_per_q <= '0;
      act_cmp_q <= '0;
      div_q     <= '0;
      pwm_q     <= 1'b0;
      per_f_q   <= 1'b0;
      duty_f_q  <= 1'b0;
      trig_q    <= 1'b0;
    end else begin
      cnt_q     <= cnt_n;
      up_q      <= up_n;
      act_per_q <= act_per_n;
      act_cmp_q <= act_cmp_n;
      div_q     <= div_n;
      pwm_q     <= pwm_d;
      per_f_q   <= per_f_n;
      duty_f_q  <= duty_f_n;
      trig_q    <= trig_n;
    end
  end

  assign pwm_o       = pwm_q ^ cfg.inv;
  assign per_flag_o  = per_f_q;
  assign duty_flag_o = duty_f_q;
  assign trig_o      = trig_q;

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.en |-> cnt_q <= act_per_q);

  // R6
  cmp_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && !(tick && cnt_q == '0)) |=> $stable(act_cmp_q));

  // R7
  zero_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && act_per_q == '0 && shd_per == '0) |=> cnt_q == '0);

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_f_q && !clr_per) |=> per_f_q);

endmodule

// File: rtl/pwm_pair_gen.sv
module pwm_pair_gen
  import pwmpair_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 8,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [PAIR-1:0]   pwm_out,
  output logic [PAIR-1:0]   period_flag,
  output logic [PAIR-1:0]   duty_flag,
  output logic [PAIR-1:0]   adc_trig
);

  logic [PSC_W-1:0]           psc;
  chan_cfg_t [PAIR-1:0]       cfg;
  logic [PAIR-1:0][CNT_W-1:0] shd_per, shd_cmp;
  logic [PAIR-1:0]            clr_per, clr_duty;
  logic                       psc_tick;

  pwmpair_regs #(
    .CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .psc_o(psc), .cfg_o(cfg), .per_o(shd_per), .cmp_o(shd_cmp),
    .clr_per_o(clr_per), .clr_duty_o(clr_duty)
  );

  pwmpair_psc #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .psc(psc), .tick_o(psc_tick)
  );

  for (genvar i = 0; i < PAIR; i++) begin : g_ch
    pwmpair_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .psc_tick(psc_tick), .cfg(cfg[i]),
      .shd_per(shd_per[i]), .shd_cmp(shd_cmp[i]),
      .clr_per(clr_per[i]), .clr_duty(clr_duty[i]),
      .pwm_o(pwm_out[i]), .per_flag_o(period_flag[i]),
      .duty_flag_o(duty_flag[i]), .trig_o(adc_trig[i])
    );
  end

endmodule

// File: tb/pwm_pair_gen_test.sv
module pwm_pair_gen_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic [1:0]  pwm_out, period_flag, duty_flag, adc_trig;

  int checks = 0;
  int errors = 0;

  typedef struct { string tag; int hi; int per; } exp_t;
  exp_t sb[$];

  pwm_pair_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out), .period_flag(period_flag), .duty_flag(duty_flag), .adc_trig(adc_trig)
  );

  always #2.5ns clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Monitor: measures high time and period between rising edges
  int  mon_ch = 0;
  bit  mon_on = 0;
  int  cyc = 0, t_r = 0, t_f = 0;
  bit  have_r = 0, have_f = 0, prev = 0, cur = 0;
  exp_t item;

  always @(negedge clk) begin
    cyc++;
    cur = pwm_out[mon_ch];
    if (!mon_on) begin
      have_r = 0; have_f = 0;
    end else if (cur && !prev) begin
      if (have_r && have_f && sb.size() > 0) begin
        item = sb.pop_front();
        check({item.tag, " high time"}, t_f - t_r, item.hi);
        check({item.tag, " period"}, cyc - t_r, item.per);
      end
      t_r = cyc; have_r = 1; have_f = 0;
    end else if (!cur && prev && have_r) begin
      t_f = cyc; have_f = 1;
    end
    prev = cur;
  end

  // Driver: queues the expected waveform and waits for the monitor
  task automatic expect_wave(input int ch, input int hi, input int per, input string tag);
    mon_ch = ch;
    @(negedge clk);
    for (int k = 0; k < 3; k++) sb.push_back('{tag, hi, per});
    mon_on = 1;
    for (int w = 0; w < per * 6 + 100 && sb.size() > 0; w++) @(negedge clk);
    if (sb.size() > 0) begin
      checks++; errors++;
      $display("FAIL %s: %0d waveform results missing, expected 0", tag, sb.size());
      sb.delete();
    end
    mon_on = 0;
    @(negedge clk);
  endtask

  task automatic window(input int ch, input int n, output int chg, output int pulses,
                        output int co_r, output int co_f);
    logic p, c;
    chg = 0; pulses = 0; co_r = 0; co_f = 0;
    @(negedge clk);
    p = pwm_out[ch];
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      c = pwm_out[ch];
      if (c != p) chg++;
      if (adc_trig[ch]) begin
        pulses++;
        if (c && !p) co_r++;
        if (!c && p) co_f++;
      end
      p = c;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, got 1 expired expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int chg, pul, cr, cf, n;
    logic lv, pv, cv;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    idle(5);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 pwm_out", int'(pwm_out), 0);
    check("R1 flags", int'({period_flag, duty_flag}), 0);
    check("R1 adc_trig", int'(adc_trig), 0);

    // R4: edge style, prescaler 1, divide by 1, period 9, compare 4
    wr(0, 1); wr(2, 'h44);
    wr(5, 9); wr(6, 4); wr(7, 9); wr(8, 4);
    wr(1, 'h0001); idle(50);
    expect_wave(0, 8, 20, "R4 edge");

    // R3: divider code 0 is divide by 2, code 3 divide by 16
    wr(1, 0); wr(2, 'h40); wr(1, 1); idle(50);
    expect_wave(0, 16, 40, "R3 div2");
    wr(1, 0); wr(2, 'h43); wr(5, 3); wr(6, 2); wr(1, 1); idle(300);
    expect_wave(0, 64, 128, "R3 div16");

    // R5: centre style, period 5, compare 3
    wr(1, 0); wr(2, 'h44); wr(5, 5); wr(6, 3); wr(1, 'h0005); idle(50);
    expect_wave(0, 10, 20, "R5 center");

    // R8: inverted edge output
    wr(1, 0); wr(5, 9); wr(6, 4); wr(1, 'h0011); idle(50);
    expect_wave(0, 12, 20, "R8 invert");

    // R2: prescaler 3 slows both channels together
    wr(1, 0); wr(0, 3); wr(1, 'h0003); idle(100);
    expect_wave(1, 16, 40, "R2 shared ch1");
    expect_wave(0, 16, 40, "R2 shared ch0");
    // R2: prescaler 0 stalls both
    wr(0, 0); idle(10);
    window(0, 300, chg, pul, cr, cf);
    check("R2 stall ch0 changes", chg, 0);
    window(1, 300, chg, pul, cr, cf);
    check("R2 stall ch1 changes", chg, 0);

    // R6: compare written in the low phase waits for the next period
    wr(0, 1); wr(1, 'h0001); idle(60);
    @(negedge clk); pv = pwm_out[0];
    forever begin
      @(negedge clk); cv = pwm_out[0];
      if (pv && !cv) break;
      pv = cv;
    end
    wr_en = 1'b1; wr_addr = 4'd6; wr_data = 16'd8;
    n = 0;
    do begin
      @(negedge clk); wr_en = 1'b0; n++;
    end while (!pwm_out[0] && n < 100);
    check("R6 low phase after late compare write", n, 12);
    expect_wave(0, 16, 20, "R6 new compare");

    // R7: period 0 stops the counter with the output held high
    wr(5, 0); idle(60);
    wr(4, 'hF); idle(2);
    window(0, 200, chg, pul, cr, cf);
    check("R7 stopped changes", chg, 0);
    check("R7 held level", int'(pwm_out[0]), 1);
    check("R7 no period event", int'(period_flag[0]), 0);

    // R9: disabled channels idle low with no events
    wr(1, 0); wr(5, 9); wr(6, 4); idle(10);
    wr(4, 'hF);
    window(0, 200, chg, pul, cr, cf);
    check("R9 disabled output", int'(pwm_out), 0);
    check("R9 disabled changes", chg, 0);
    check("R9 no flags", int'({period_flag, duty_flag}), 0);

    // R10: up-select duty never fires in edge style, fires in centre style
    wr(1, 'h0101); idle(40); wr(4, 'h3); idle(200);
    check("R10 duty up in edge style", int'(duty_flag[0]), 0);
    check("R10 period at bottom", int'(period_flag[0]), 1);
    wr(1, 'h0105); idle(200);
    check("R10 duty up in centre style", int'(duty_flag[0]), 1);
    wr(1, 0); wr(4, 'h3); idle(2);
    check("R10 write-one clear", int'({period_flag[0], duty_flag[0]}), 0);
    // R10: top-select period event in edge style
    wr(1, 'h0041); idle(60);
    check("R10 period at top", int'(period_flag[0]), 1);

    // R11: each trigger source alone, edge style period 20 cycles
    wr(1, 'h0001); idle(60);
    wr(3, 'h1); idle(5);
    window(0, 200, chg, pul, cr, cf);
    check("R11 rise pulses", pul, 10);
    check("R11 rise aligned", cr, 10);
    wr(3, 'h2); idle(5);
    window(0, 200, chg, pul, cr, cf);
    check("R11 fall pulses", pul, 10);
    check("R11 fall aligned", cf, 10);
    wr(3, 'h4); idle(5);
    window(0, 200, chg, pul, cr, cf);
    check("R11 top pulses", pul, 10);
    wr(3, 'h8); idle(5);
    window(0, 200, chg, pul, cr, cf);
    check("R11 bottom pulses", pul, 10);
    wr(3, 'h0); idle(5);
    window(0, 200, chg, pul, cr, cf);
    check("R11 disabled triggers", pul, 0);

    // R12: channel 1 register slots drive channel 1 only
    wr(1, 0); wr(7, 4); wr(8, 1); wr(1, 'h0002); idle(50);
    expect_wave(1, 2, 10, "R12 ch1 slots");
    lv = pwm_out[0];
    check("R12 ch0 idle", int'(lv), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule